// File: doc/BRIEF.md
# Power Button and Supply On/Off Controller

This block sits in the standby power domain and owns the enable line of the main power supply. The supply can be switched on by a debounced press of the power button, by a wake-up request, by a software on command, or by the recovery policy that applies when standby power comes back. It can be switched off by a software off command or by holding the button down for a long time. A short press while the system is running does not cut power: it produces a one-cycle event so that software can shut down in an orderly way.

Every switch-on opens a guard window measured in slow ticks. If main power-good is not reported inside that window, the enable is withdrawn and a fail flag is raised. The debounced button level is also passed out unchanged for the chipset. All timing runs from a 32.768 kHz tick pulse, which is one clock cycle wide. The block keeps the last supply state in a register that only the backup-battery reset clears, so a standby reset does not erase it and a restore policy can use it.

Top module: `psu_onoff_ctrl`

## Requirements
- R1: While the standby reset is applied, and with recovery setting 00 after it is released, psu_en, pbtn_out, pbtn_evt and crowbar_fail are all 0.
- R2: btn_in (1 = pressed) passes through a two-flop synchronizer. A new level reaches pbtn_out only after it has been seen on DEB_TICKS consecutive ticks. A shorter pulse has no effect on pbtn_out or on psu_en.
- R3: While the supply is off, a debounced press, a wake_req pulse or an sw_on pulse each raise psu_en on the next clock.
- R4: If the debounced button stays pressed for HOLD_TICKS ticks, psu_en is forced to 0. The release that follows that hold produces no pbtn_evt.
- R5: After psu_en rises, if main_pg is still 0 on the (crowbar_lim+1)-th tick, psu_en drops and crowbar_fail is set to 1. crowbar_fail stays set until the next accepted on request clears it.
- R6: A press that begins while the supply is on and powered and is released before the hold limit gives exactly one one-cycle pbtn_evt pulse, and psu_en stays 1.
- R7: An sw_off pulse turns the supply off, whether it is still waiting for power-good or is fully on.
- R8: The recovery setting recov_mode is sampled on the first clock after the standby reset is released. 00 gives off, 01 gives on, 10 restores the last state and 11 gives off. The last state is cleared only by vbat_rst_n.
- R9: An sw_off in the same cycle as any on request keeps the supply off.
- R10: The supply reaches its fully-on state only from a cycle in which main_pg was 1. Once fully on, a later loss of main_pg does not drop psu_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby clock |
| rst_n | input | 1 | Standby reset, active low, asynchronous |
| vbat_rst_n | input | 1 | Backup-battery reset, active low; clears the last-state register |
| tick | input | 1 | 32.768 kHz timebase pulse, one clk wide |
| btn_in | input | 1 | Raw power button, 1 = pressed |
| wake_req | input | 1 | Wake-up on request pulse |
| sw_on | input | 1 | Software-emulated on command pulse |
| sw_off | input | 1 | Software-emulated off command pulse |
| main_pg | input | 1 | Main supply power-good |
| recov_mode | input | 2 | Power-fail recovery policy |
| crowbar_lim | input | CB_W | Crowbar window length in ticks (window ends on tick crowbar_lim+1) |
| psu_en | output | 1 | Supply enable |
| pbtn_out | output | 1 | Debounced button mirror |
| pbtn_evt | output | 1 | One-cycle short-press event |
| crowbar_fail | output | 1 | Sticky power-good timeout flag |

## Verification
The hardest case to reach is the restore policy. It only shows up after a standby reset that falls between earlier on and off decisions, while the battery-domain state is left in place. The stimulus switches the supply on, applies only rst_n under each recovery setting, then switches off and repeats. It then applies vbat_rst_n as well, to show that the stored state is lost. The long-press override is reached by holding the button through a shortened hold limit set by parameter. A bench model tracks every tick, so the exact cycle of the forced off is compared.

// File: rtl/psu_onoff_ctrl.sv
module psu_onoff_ctrl #(
  parameter int DEB_TICKS  = 524,
  parameter int HOLD_TICKS = 131072,
  parameter int CB_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vbat_rst_n,
  input  logic            tick,
  input  logic            btn_in,
  input  logic            wake_req,
  input  logic            sw_on,
  input  logic            sw_off,
  input  logic            main_pg,
  input  logic [1:0]      recov_mode,
  input  logic [CB_W-1:0] crowbar_lim,
  output logic            psu_en,
  output logic            pbtn_out,
  output logic            pbtn_evt,
  output logic            crowbar_fail
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_TICKS - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_ON} st_t;

  st_t             st, st_nxt;
  logic            s1, s2, deb, deb_q, held, armed, rec_pend, last_on, evt_q, fail_q;
  logic [DW-1:0]   dcnt;
  logic [HW-1:0]   hcnt;
  logic [CB_W-1:0] cbcnt;

  wire rise     = deb & ~deb_q;
  wire fall     = ~deb & deb_q;
  wire hold_hit = deb & ~held & tick & (hcnt == HOLD_LAST);
  wire kill     = hold_hit | sw_off;
  wire rec_fire = rec_pend & ((recov_mode == 2'b01) | ((recov_mode == 2'b10) & last_on));
  wire on_req   = rec_fire | wake_req | sw_on | rise;
  wire cb_out   = (st == S_WAIT) & ~main_pg & tick & (cbcnt == crowbar_lim);

  always_comb begin
    st_nxt = st;
    case (st)
      S_OFF:   if (on_req && !kill) st_nxt = S_WAIT;
      S_WAIT:  if (kill) st_nxt = S_OFF;
               else if (main_pg) st_nxt = S_ON;
               else if (cb_out) st_nxt = S_OFF;
      default: if (kill) st_nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; deb <= 1'b0; deb_q <= 1'b0; dcnt <= '0;
      hcnt <= '0; held <= 1'b0; armed <= 1'b0; st <= S_OFF; cbcnt <= '0;
      fail_q <= 1'b0; evt_q <= 1'b0; rec_pend <= 1'b1;
    end else begin
      s1 <= btn_in;
      s2 <= s1;
      deb_q <= deb;
      rec_pend <= 1'b0;
      if (s2 == deb) dcnt <= '0;
      else if (tick) begin
        if (dcnt == DEB_LAST) begin deb <= s2; dcnt <= '0; end
        else dcnt <= dcnt + 1'b1;
      end
      if (!deb) begin hcnt <= '0; held <= 1'b0; end
      else if (tick && !held) begin
        if (hcnt == HOLD_LAST) held <= 1'b1;
        else hcnt <= hcnt + 1'b1;
      end
      if (rise && st == S_ON) armed <= 1'b1;
      else if (fall) armed <= 1'b0;
      evt_q <= fall & armed & ~held & (st == S_ON) & ~kill;
      if (st == S_OFF && st_nxt == S_WAIT) begin cbcnt <= '0; fail_q <= 1'b0; end
      else if (st == S_WAIT && tick) cbcnt <= cbcnt + 1'b1;
      if (cb_out && !kill) fail_q <= 1'b1;
      st <= st_nxt;
    end
  end

  always_ff @(posedge clk or negedge vbat_rst_n) begin
    if (!vbat_rst_n) last_on <= 1'b0;
    else if (rst_n && st_nxt != st) last_on <= (st_nxt != S_OFF);
  end

  assign psu_en       = (st != S_OFF);
  assign pbtn_out     = deb;
  assign pbtn_evt     = evt_q;
  assign crowbar_fail = fail_q;

  a_r2_mirror_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(pbtn_out));
  a_r4_hold_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !psu_en);
  a_r5_crowbar_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crowbar_fail) |-> $fell(psu_en));
  a_r6_evt_while_on: assert property (@(posedge clk) disable iff (!rst_n)
    pbtn_evt |-> psu_en && !$past(pbtn_evt));
  a_r9_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |=> !psu_en);
  a_r10_on_needs_pg: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ON && $past(st) == S_WAIT) |-> $past(main_pg));
endmodule

// File: tb/tb_psu_onoff_ctrl.sv
`timescale 1ns/1ps
module tb_psu_onoff_ctrl;
  localparam int DEB = 4, HOLD = 30, CBW = 8;
  logic clk = 0, rst_n = 0, vbat_rst_n = 0, btn_in = 0, wake_req = 0, sw_on = 0, sw_off = 0, main_pg = 0;
  logic [1:0] recov_mode = 2'b00;
  logic [CBW-1:0] crowbar_lim = 8'd3;
  logic psu_en, pbtn_out, pbtn_evt, crowbar_fail;
  logic [1:0] tcnt = 0;
  wire tick = (tcnt == 2'd3);
  int tests = 0, fails = 0, evt_n = 0, cyc = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1'b1;
  always @(posedge clk) if (rst_n && pbtn_evt) evt_n++;

  psu_onoff_ctrl #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .CB_W(CBW)) dut (
    .clk(clk), .rst_n(rst_n), .vbat_rst_n(vbat_rst_n), .tick(tick), .btn_in(btn_in),
    .wake_req(wake_req), .sw_on(sw_on), .sw_off(sw_off), .main_pg(main_pg),
    .recov_mode(recov_mode), .crowbar_lim(crowbar_lim), .psu_en(psu_en),
    .pbtn_out(pbtn_out), .pbtn_evt(pbtn_evt), .crowbar_fail(crowbar_fail));

  // behavioural reference: mode 0 off, 1 waiting for power-good, 2 on
  int ms1, ms2, mdeb, mdebq, mdc, mhc, mheld, marm, mst, mcb, mfail, mlast, mpend, mevt;
  initial begin
    ms1 = 0; ms2 = 0; mdeb = 0; mdebq = 0; mdc = 0; mhc = 0; mheld = 0; marm = 0;
    mst = 0; mcb = 0; mfail = 0; mlast = 0; mpend = 1; mevt = 0;
  end
  always @(posedge clk) begin
    int rise, fall, hit, kill, onr, nst;
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; mdeb = 0; mdebq = 0; mdc = 0; mhc = 0; mheld = 0; marm = 0;
      mst = 0; mcb = 0; mfail = 0; mpend = 1; mevt = 0;
    end else begin
      rise = (mdeb && !mdebq); fall = (!mdeb && mdebq);
      hit  = (mdeb && !mheld && tick && mhc == HOLD - 1);
      kill = hit || sw_off;
      onr  = (mpend && (recov_mode == 1 || (recov_mode == 2 && mlast))) || wake_req || sw_on || rise;
      nst = mst;
      if (mst == 0) begin
        if (onr && !kill) begin nst = 1; mcb = 0; mfail = 0; end
      end else if (kill) nst = 0;
      else if (mst == 1) begin
        if (main_pg) nst = 2;
        else if (tick) begin
          if (mcb == crowbar_lim) begin nst = 0; mfail = 1; end
          else mcb = mcb + 1;
        end
      end
      mevt = (fall && marm && !mheld && mst == 2 && !kill);
      if (rise && mst == 2) marm = 1; else if (fall) marm = 0;
      if (nst != mst) mlast = (nst != 0);
      mst = nst; mpend = 0;
      mdebq = mdeb;
      if (!mdeb) begin mhc = 0; mheld = 0; end
      else if (tick && !mheld) begin
        if (mhc == HOLD - 1) mheld = 1; else mhc = mhc + 1;
      end
      if (ms2 == mdeb) mdc = 0;
      else if (tick) begin
        if (mdc == DEB - 1) begin mdeb = ms2; mdc = 0; end else mdc = mdc + 1;
      end
      ms2 = ms1; ms1 = btn_in;
    end
    if (!vbat_rst_n) mlast = 0;
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk({cur, " psu_en"}, psu_en, mst != 0);
      chk({cur, " pbtn_out"}, pbtn_out, mdeb);
      chk({cur, " pbtn_evt"}, pbtn_evt, mevt);
      chk({cur, " crowbar_fail"}, crowbar_fail, mfail);
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic ticks(int n); step(4 * n); endtask
  task automatic pulse(ref logic s); s = 1; step(1); s = 0; endtask
  task automatic sreset(logic [1:0] m, logic vb);
    recov_mode = m; rst_n = 0; vbat_rst_n = vb ? 1'b0 : 1'b1; step(3);
    vbat_rst_n = 1; rst_n = 1; step(4);
  endtask

  initial begin
    int e0;
    step(1);
    step(3);
    @(negedge clk); chk("R1 psu_en in reset", psu_en, 0); chk("R1 pbtn_out in reset", pbtn_out, 0);
    step(1); vbat_rst_n = 1; rst_n = 1; step(4);
    @(negedge clk); chk("R1 psu_en after reset", psu_en, 0); chk("R1 crowbar_fail", crowbar_fail, 0);
    step(1);

    cur = "R2"; btn_in = 1; ticks(2); btn_in = 0; ticks(8);
    @(negedge clk); chk("R2 glitch ignored pbtn_out", pbtn_out, 0); chk("R2 glitch ignored psu_en", psu_en, 0);
    step(1);

    cur = "R3"; main_pg = 1; btn_in = 1; ticks(8);
    @(negedge clk); chk("R3 press pbtn_out", pbtn_out, 1); chk("R3 press turns on", psu_en, 1);
    step(1); btn_in = 0; ticks(8);
    @(negedge clk); chk("R3 turn-on press gives no event", evt_n, 0);
    step(1);

    cur = "R6"; btn_in = 1; ticks(8); btn_in = 0; ticks(8);
    @(negedge clk); chk("R6 short press event count", evt_n, 1); chk("R6 stays on", psu_en, 1);
    step(1);

    cur = "R4"; e0 = evt_n; btn_in = 1; ticks(45);
    @(negedge clk); chk("R4 hold forces off", psu_en, 0); chk("R4 button still mirrored", pbtn_out, 1);
    step(1); btn_in = 0; ticks(8);
    @(negedge clk); chk("R4 no event after hold", evt_n, e0); chk("R4 stays off", psu_en, 0);
    step(1);

    cur = "R3"; pulse(wake_req); step(2);
    @(negedge clk); chk("R3 wake turns on", psu_en, 1);
    step(1);
    cur = "R10"; main_pg = 0; ticks(10);
    @(negedge clk); chk("R10 pg loss keeps on", psu_en, 1);
    step(1); main_pg = 1;
    cur = "R7"; pulse(sw_off); step(2);
    @(negedge clk); chk("R7 sw_off from on", psu_en, 0);
    step(1);

    cur = "R5"; main_pg = 0; pulse(sw_on); step(1);
    @(negedge clk); chk("R5 waiting enable", psu_en, 1);
    step(1); ticks(8);
    @(negedge clk); chk("R5 crowbar drop", psu_en, 0); chk("R5 crowbar flag", crowbar_fail, 1);
    step(1); crowbar_lim = 8'd0; pulse(sw_on); ticks(4);
    @(negedge clk); chk("R5 zero window drop", crowbar_fail, 1);
    step(1); crowbar_lim = 8'd3; main_pg = 1; pulse(sw_on); step(2);
    @(negedge clk); chk("R5 flag cleared on request", crowbar_fail, 0); chk("R5 on with pg", psu_en, 1);
    step(1);
    cur = "R7"; main_pg = 0; pulse(sw_off); main_pg = 1; step(2);
    main_pg = 0; pulse(sw_on); pulse(sw_off); main_pg = 1; step(2);
    @(negedge clk); chk("R7 sw_off while waiting", psu_en, 0);
    step(1);

    cur = "R9"; sw_on = 1; sw_off = 1; step(1); sw_on = 0; sw_off = 0; step(2);
    @(negedge clk); chk("R9 off wins", psu_en, 0);
    step(1); wake_req = 1; sw_off = 1; step(1); wake_req = 0; sw_off = 0; step(2);
    @(negedge clk); chk("R9 off beats wake", psu_en, 0);
    step(1);

    cur = "R8"; pulse(sw_on); step(2);
    sreset(2'b10, 0);
    @(negedge clk); chk("R8 restore last on", psu_en, 1);
    step(1); sreset(2'b00, 0);
    @(negedge clk); chk("R8 always off", psu_en, 0);
    step(1); sreset(2'b10, 0);
    @(negedge clk); chk("R8 reset keeps last state", psu_en, 1);
    step(1); pulse(sw_off); step(2); sreset(2'b10, 0);
    @(negedge clk); chk("R8 restore last off", psu_en, 0);
    step(1); sreset(2'b01, 0);
    @(negedge clk); chk("R8 always on", psu_en, 1);
    step(1); sreset(2'b11, 0);
    @(negedge clk); chk("R8 setting 11 off", psu_en, 0);
    step(1); pulse(sw_on); step(2); sreset(2'b10, 1);
    @(negedge clk); chk("R8 battery reset clears last", psu_en, 0);
    step(1); step(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule